// File: doc/BRIEF.md
# Data Bus Line Fault Tester

This block checks the data lines of a memory bus for shorts and opens. Once started, it works through a fixed set of stripe patterns. Together the patterns place every pair of data lines in opposite states at least once, whatever the board routing. For each pattern it writes the pattern to a target word. It then writes a fixed decoy value to the next word up, so the bus is driven to other levels and a floating line cannot simply hold the value just written. Last, it reads the target word back exactly once.

The single value captured from that read is compared with the pattern. The same value is reported on a log port when the two differ. A mismatch never stops the run: every pattern is always tried, and any mismatch sets a sticky fail flag. The fail flag holds until the next start. A mask input can flip chosen bits of the captured read data, so that the detection path can be exercised on working hardware.

Top module: `dbus_probe`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done, fail, mem_req and log_valid are all low.
- R2: The pattern set has 2*log2(DATA_W) entries. For DATA_W = 64 the first six entries hold stripes of width 1, 2, 4, 8, 16 and 32 bits: bit i of entry k is bit k of i, giving AAAA…, CCCC…, F0F0…, FF00FF00…, FFFF0000…, FFFFFFFF00000000. Entry k at or past the half is the bitwise complement of entry (last − k), so the set ends with 3333… and then 5555….
- R3: For each pattern, in ascending entry order, the block makes exactly three accesses in this order: a write of the pattern to the base word, a write of the decoy 0123456789ABCDEF to base+1 (modulo 2^ADDR_W), and one read of the base word. No other access is made.
- R4: The base address is sampled in the cycle start is taken in idle. Changes on base_addr and further start pulses have no effect while the run is in progress.
- R5: A request holds mem_req, mem_we, mem_addr and mem_wdata unchanged until the cycle in which mem_gnt is high.
- R6: A read is complete only when mem_rvalid is high after its grant. mem_rvalid pulses at any other time are ignored.
- R7: When the captured read word differs from the pattern, log_valid pulses for one cycle. In that cycle log_addr is the base address, log_exp is the pattern and log_obs is the captured word. There is no pulse when the two are equal.
- R8: A mismatch does not end the run. fail rises after the first mismatch of a run, stays high through the rest of the run and after done, and clears only when the next start is taken.
- R9: busy is high from the cycle after start until done. done is a one-cycle pulse after the last compare, and busy is low in the done cycle.
- R10: With INJ_EN = 1, the captured word is mem_rdata XOR inj_mask, sampled in the cycle the read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (taken only while idle) |
| base_addr | input | ADDR_W | Word address of the target word |
| inj_mask | input | DATA_W | Bits XORed into the captured read data |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch result of the last run |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Access accepted in this cycle |
| mem_rdata | input | DATA_W | Read data |
| mem_rvalid | input | 1 | Read data valid |
| log_valid | output | 1 | Mismatch report strobe |
| log_addr | output | ADDR_W | Address of the failing word |
| log_exp | output | DATA_W | Pattern written |
| log_obs | output | DATA_W | Value read back |

## Verification
The bench builds the block with DATA_W = 64, ADDR_W = 12 and INJ_EN = 1. This gives the full twelve-entry pattern set, and it puts the top of the address space close enough to test that the decoy address wraps from 0xFFF to 0x000. The memory model around the block withholds grants at random, returns read data after random delays and sends stray read-valid pulses. It can also play stuck-high lines, stuck-low lines, a wired-AND short between neighbouring lines and a floating bus that echoes the last write. The expected log entries for each fault are computed from the pattern set.

// File: rtl/dbus_probe_pkg.sv
package dbus_probe_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WPAT,
      ST_WDEC,
      ST_RREQ,
      ST_RWAIT,
      ST_CMP,
      ST_FIN
   } probe_st_e;

endpackage

// File: rtl/dbus_probe_patgen.sv
module dbus_probe_patgen #(
   parameter int DATA_W  = 64,
   parameter int NUM_PAT = 12,
   parameter int IDX_W   = 4
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] pat
);
   localparam int HALF = NUM_PAT / 2;

   logic [DATA_W-1:0] stripe [HALF];

   // stripe k: bit i takes bit k of the index i
   for (genvar gk = 0; gk < HALF; gk++) begin : g_stripe
      for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
         assign stripe[gk][gi] = ((gi >> gk) & 1) != 0;
      end
   end

   always_comb begin
      pat = '0;
      for (int k = 0; k < HALF; k++) begin
         if (idx == IDX_W'(k))             pat = stripe[k];
         if (idx == IDX_W'(NUM_PAT - 1 - k)) pat = ~stripe[k];
      end
   end

endmodule

// File: rtl/dbus_probe_seq.sv
module dbus_probe_seq
   import dbus_probe_pkg::*;
#(
   parameter int                ADDR_W  = 16,
   parameter int                DATA_W  = 64,
   parameter int                NUM_PAT = 12,
   parameter int                IDX_W   = 4,
   parameter logic [DATA_W-1:0] DECOY   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [DATA_W-1:0] pat_in,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] base_q,
   output logic              clr,
   output logic              cap_en,
   output logic              cmp_en,
   output logic              busy,
   output logic              done
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PAT - 1);

   probe_st_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         base_q <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               base_q <= base_in;
               idx    <= '0;
               state  <= ST_WPAT;
            end
            ST_WPAT:  if (mem_gnt) state <= ST_WDEC;
            ST_WDEC:  if (mem_gnt) state <= ST_RREQ;
            ST_RREQ:  if (mem_gnt) state <= ST_RWAIT;
            ST_RWAIT: if (mem_rvalid) state <= ST_CMP;
            ST_CMP: begin
               if (idx == LAST_IDX) begin
                  state <= ST_FIN;
               end else begin
                  idx   <= idx + 1'b1;
                  state <= ST_WPAT;
               end
            end
            ST_FIN:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = base_q;
      mem_wdata = pat_in;
      case (state)
         ST_WPAT: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         ST_WDEC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = base_q + ADDR_W'(1);
            mem_wdata = DECOY;
         end
         ST_RREQ: mem_req = 1'b1;
         default: ;
      endcase
   end

   assign clr    = (state == ST_IDLE) && start;
   assign cap_en = (state == ST_RWAIT) && mem_rvalid;
   assign cmp_en = (state == ST_CMP);
   assign busy   = (state != ST_IDLE) && (state != ST_FIN);
   assign done   = (state == ST_FIN);

   p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                                 && $stable(mem_wdata)));
   p_read_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_gnt) |=> !mem_req);
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_base_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(base_q));

endmodule

// File: rtl/dbus_probe_cmp.sv
module dbus_probe_cmp #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 16,
   parameter bit INJ_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              cap_en,
   input  logic              cmp_en,
   input  logic [DATA_W-1:0] rdata,
   input  logic [DATA_W-1:0] inj_mask,
   input  logic [DATA_W-1:0] exp_pat,
   input  logic [ADDR_W-1:0] base,
   output logic              fail,
   output logic              log_valid,
   output logic [ADDR_W-1:0] log_addr,
   output logic [DATA_W-1:0] log_exp,
   output logic [DATA_W-1:0] log_obs
);
   logic [DATA_W-1:0] rd_eff;
   logic [DATA_W-1:0] cap_q;

   if (INJ_EN) begin : g_inj
      assign rd_eff = rdata ^ inj_mask;
   end else begin : g_noinj
      logic unused_mask;
      assign unused_mask = ^inj_mask;
      assign rd_eff      = rdata;
   end

   // the read word is captured once and reused for compare and log
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q <= '0;
         fail  <= 1'b0;
      end else begin
         if (cap_en) cap_q <= rd_eff;
         if (clr)            fail <= 1'b0;
         else if (log_valid) fail <= 1'b1;
      end
   end

   assign log_valid = cmp_en && (cap_q != exp_pat);
   assign log_addr  = base;
   assign log_exp   = exp_pat;
   assign log_obs   = cap_q;

   p_fail_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clr) |=> fail);
   p_log_sets_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |=> fail);
   p_log_after_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      log_valid |-> $past(cap_en));

endmodule

// File: rtl/dbus_probe.sv
module dbus_probe
   import dbus_probe_pkg::*;
#(
   parameter int                DATA_W = 64,
   parameter int                ADDR_W = 16,
   parameter bit                INJ_EN = 1'b1,
   parameter logic [DATA_W-1:0] DECOY  = DATA_W'(64'h0123456789ABCDEF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [DATA_W-1:0] inj_mask,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   output logic              log_valid,
   output logic [ADDR_W-1:0] log_addr,
   output logic [DATA_W-1:0] log_exp,
   output logic [DATA_W-1:0] log_obs
);
   localparam int NUM_PAT = 2 * $clog2(DATA_W);
   localparam int IDX_W   = $clog2(NUM_PAT);

   if (DATA_W < 4 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("dbus_probe: DATA_W must be a power of two, at least 4");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("dbus_probe: ADDR_W must be at least 2");
   end

   logic [IDX_W-1:0]  idx;
   logic [DATA_W-1:0] pat;
   logic [ADDR_W-1:0] base_q;
   logic              clr, cap_en, cmp_en;

   dbus_probe_patgen #(
      .DATA_W (DATA_W),
      .NUM_PAT(NUM_PAT),
      .IDX_W  (IDX_W)
   ) u_patgen (
      .idx(idx),
      .pat(pat)
   );

   dbus_probe_seq #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NUM_PAT(NUM_PAT),
      .IDX_W  (IDX_W),
      .DECOY  (DECOY)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .base_in   (base_addr),
      .pat_in    (pat),
      .mem_gnt   (mem_gnt),
      .mem_rvalid(mem_rvalid),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .idx       (idx),
      .base_q    (base_q),
      .clr       (clr),
      .cap_en    (cap_en),
      .cmp_en    (cmp_en),
      .busy      (busy),
      .done      (done)
   );

   dbus_probe_cmp #(
      .DATA_W(DATA_W),
      .ADDR_W(ADDR_W),
      .INJ_EN(INJ_EN)
   ) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .cap_en   (cap_en),
      .cmp_en   (cmp_en),
      .rdata    (mem_rdata),
      .inj_mask (inj_mask),
      .exp_pat  (pat),
      .base     (base_q),
      .fail     (fail),
      .log_valid(log_valid),
      .log_addr (log_addr),
      .log_exp  (log_exp),
      .log_obs  (log_obs)
   );

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !log_valid));

endmodule

// File: tb/dbus_probe_bench.sv
module dbus_probe_bench;
   localparam int DW = 64;
   localparam int AW = 12;
   localparam logic [63:0] DEC = 64'h0123456789ABCDEF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] base_addr = '0;
   logic [DW-1:0] inj_mask = '0;
   logic          busy, done, fail, mem_req, mem_we, log_valid;
   logic [AW-1:0] mem_addr, log_addr;
   logic [DW-1:0] mem_wdata, log_exp, log_obs;
   logic          mem_gnt = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          mem_rvalid = 1'b0;

   always #5 clk = ~clk;

   dbus_probe #(.DATA_W(DW), .ADDR_W(AW), .INJ_EN(1'b1)) u_dbus_probe (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .inj_mask(inj_mask), .busy(busy), .done(done), .fail(fail),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .mem_rvalid(mem_rvalid), .log_valid(log_valid), .log_addr(log_addr),
      .log_exp(log_exp), .log_obs(log_obs));

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // fault model: 0 good, 1 stuck high, 2 floating bus, 3 wired-AND short, 4 stuck low
   int            mode = 0;
   logic [63:0]   fmask = '0;
   int            sbit = 0;
   logic [AW-1:0] base_exp = '0;
   logic [63:0]   mem [16];
   logic [63:0]   last_bus = '0;
   int            step = 0;
   int            rd_cnt = 0;
   bit            rd_pend = 1'b0;
   logic [3:0]    rd_idx = '0;
   int            log_seen = 0;
   int            next_j = 0;
   bit            model_on = 1'b0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   function automatic logic [63:0] pat_of(input int j);
      case (j)
         0:  return 64'hAAAAAAAAAAAAAAAA;
         1:  return 64'hCCCCCCCCCCCCCCCC;
         2:  return 64'hF0F0F0F0F0F0F0F0;
         3:  return 64'hFF00FF00FF00FF00;
         4:  return 64'hFFFF0000FFFF0000;
         5:  return 64'hFFFFFFFF00000000;
         6:  return 64'h00000000FFFFFFFF;
         7:  return 64'h0000FFFF0000FFFF;
         8:  return 64'h00FF00FF00FF00FF;
         9:  return 64'h0F0F0F0F0F0F0F0F;
         10: return 64'h3333333333333333;
         default: return 64'h5555555555555555;
      endcase
   endfunction

   function automatic logic [63:0] fault_rd(input logic [63:0] v, input logic [63:0] lb);
      logic [63:0] r;
      r = v;
      case (mode)
         1: r = v | fmask;
         2: r = lb;
         3: begin
            r[sbit]   = v[sbit] & v[sbit+1];
            r[sbit+1] = v[sbit] & v[sbit+1];
         end
         4: r = v & ~fmask;
         default: r = v;
      endcase
      return r;
   endfunction

   // what the block should capture for pattern j (base word holds it, bus last saw decoy)
   function automatic logic [63:0] obs_of(input int j);
      return fault_rd(pat_of(j), DEC) ^ inj_mask;
   endfunction

   // memory model and access-order checker
   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      mem_gnt    = 1'b0;
      if (model_on) begin
         if (rd_pend) begin
            rd_cnt--;
            if (rd_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = fault_rd(mem[rd_idx], last_bus);
               rd_pend    = 1'b0;
            end
         end else if ($urandom % 6 == 0) begin
            // stray read-valid with junk data must be ignored (R6)
            mem_rvalid = 1'b1;
            mem_rdata  = {$urandom, $urandom};
         end
         if (mem_req && ($urandom % 3 != 0)) begin
            logic [AW-1:0] ea;
            logic [63:0]   ed;
            logic          ew;
            int            j, k;
            mem_gnt = 1'b1;
            j = step / 3;
            k = step % 3;
            ew = (k != 2);
            ea = (k == 1) ? base_exp + AW'(1) : base_exp;
            ed = (k == 1) ? DEC : pat_of(j);
            // R3 order, R2 pattern value, R4 latched base, R5 held request
            if (ew)
               check(mem_we && mem_addr == ea && mem_wdata == ed && j < 12, "R2 R3 R4 R5",
                     {mem_we, 11'd0, mem_addr, mem_wdata[39:0]}, {ew, 11'd0, ea, ed[39:0]});
            else
               check(!mem_we && mem_addr == ea && j < 12, "R3 R4 R5",
                     {63'd0, mem_we}, {63'd0, ew});
            if (mem_we) begin
               mem[mem_addr[3:0]] = mem_wdata;
               last_bus = mem_wdata;
            end else begin
               rd_pend = 1'b1;
               rd_cnt  = 1 + int'($urandom % 3);
               rd_idx  = mem_addr[3:0];
            end
            step++;
         end
      end
   end

   // log monitor
   always @(negedge clk) begin
      if (model_on && log_valid) begin
         while (next_j < 12 && obs_of(next_j) == pat_of(next_j)) next_j++;
         check(next_j < 12, "R7", 64'(log_seen), 64'(next_j));
         if (next_j < 12) begin
            check(log_addr == base_exp, "R7", 64'(log_addr), 64'(base_exp));
            check(log_exp == pat_of(next_j), "R7", log_exp, pat_of(next_j));
            check(log_obs == obs_of(next_j), "R7 R10", log_obs, obs_of(next_j));
         end
         next_j++;
         log_seen++;
      end
   end

   task automatic run(input int m, input logic [AW-1:0] b, input logic [63:0] inj,
                      input bit mid_start);
      int exp_cnt;
      mode = m;
      inj_mask = inj;
      exp_cnt = 0;
      for (int j = 0; j < 12; j++) if (obs_of(j) != pat_of(j)) exp_cnt++;
      step = 0; log_seen = 0; next_j = 0;
      base_exp = b;
      model_on = 1'b1;
      base_addr = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      base_addr = ~b;
      check(busy == 1'b1 && fail == 1'b0, "R9 R8", {62'd0, busy, fail}, 64'd2);
      if (mid_start) begin
         repeat (15) @(negedge clk);
         start = 1'b1;
         base_addr = b ^ 12'h5A5;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && cyc < 150000) @(negedge clk);
      check(busy == 1'b0, "R9", 64'(busy), 64'd0);
      check(log_seen == exp_cnt, "R7 R6", 64'(log_seen), 64'(exp_cnt));
      check(fail == (exp_cnt > 0), "R8", 64'(fail), 64'(exp_cnt > 0));
      check(step == 36, "R3", 64'(step), 64'd36);
      @(negedge clk);
      check(done == 1'b0, "R9", 64'(done), 64'd0);
      check(fail == (exp_cnt > 0), "R8", 64'(fail), 64'(exp_cnt > 0));
      model_on = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int seed_v;
      seed_v = $urandom(32'h5EED);
      for (int i = 0; i < 16; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({busy, done, fail, mem_req, log_valid} == 5'd0, "R1",
            64'({busy, done, fail, mem_req, log_valid}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, fail, mem_req, log_valid} == 5'd0, "R1",
            64'({busy, done, fail, mem_req, log_valid}), 64'd0);
      // clean bus, random base, start pulsed mid-run (R4)
      run(0, AW'($urandom % 4000), '0, 1'b1);
      // stuck-high line: sticky fail, every pattern still run (R8)
      fmask = 64'd1 << ($urandom % 64);
      run(1, AW'($urandom % 4000), '0, 1'b0);
      // clean run clears fail from the previous run (R8)
      run(0, 12'h010, '0, 1'b0);
      // floating bus echoes the decoy on every read
      run(2, 12'h123, '0, 1'b0);
      // wired-AND short between neighbouring lines
      sbit = int'($urandom % 63);
      run(3, 12'h3C4, '0, 1'b0);
      // stuck-low line
      fmask = 64'd1 << ($urandom % 64);
      run(4, 12'h777, '0, 1'b0);
      // injected flip on good memory (R10)
      run(0, 12'h2B0, 64'h0000800000000001, 1'b0);
      // decoy address wraps at the top of the space (R3)
      run(0, 12'hFFF, '0, 1'b0);
      for (int r = 0; r < 4; r++) begin
         fmask = {$urandom, $urandom} & {$urandom, $urandom};
         run(1, AW'($urandom), {32'd0, $urandom} & 64'h0000_0000_0100_0010, 1'b0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule